// File: doc/BRIEF.md
# Dual-Overflow Watchdog Timer

This block is a memory-mapped watchdog with two clocks. Software reaches four 32-bit registers over a simple APB-style bus that runs on the peripheral clock. The counter itself runs on a separate oscillator clock. A 12-bit period value N sets the length of one overflow interval, which is 2^PRESC_W × (N+1) oscillator cycles. PRESC_W is 20 in the default build, so one interval is 1024 × 1024 × (N+1) cycles.

When the first interval ends without service, the block sets an interrupt status bit and raises `irq_o`. If a second interval in a row also ends without service, the block drives `rst_req_o` for a fixed number of oscillator cycles. Software services the watchdog by writing 1 to the interrupt register. That write clears the status and restarts the elapsed time. Writes to the control, period and elapsed registers reach the oscillator domain through toggle synchronisers. Writing a period of 1 and then setting the enable bit gives a deliberate reboot after a short time.

The registers sit at these byte addresses: 0x0 is control (bit 0 = run enable), 0x4 is period (N in bits [31:20]), 0x8 is elapsed time (bits [11:0]) and 0xC is interrupt status/clear (bit 0).

Top module: `wd_dual_ovf`

## Requirements
- R1: After reset, every register reads 0, and `irq_o` and `rst_req_o` are low.
- R2: The period register keeps only bits [31:20]. Writing 0xABCFFFFF reads back as 0xABC00000, and bits [19:0] always read 0.
- R3: While bit 0 of the control register is 0, nothing counts. The elapsed register stays 0, and neither `irq_o` nor `rst_req_o` rises.
- R4: Once counting is enabled, the first unserviced overflow comes 2^PRESC_W × (N+1) oscillator cycles after the enable takes effect. It sets bit 0 of register 0xC and raises `irq_o`.
- R5: A single overflow never requests a reset. `rst_req_o` rises only at the second consecutive overflow without service, which is 2 × 2^PRESC_W × (N+1) cycles after the enable takes effect.
- R6: A reset request holds `rst_req_o` high for exactly RST_LEN oscillator cycles. RST_LEN is 16 by default.
- R7: Writing a value with bit 0 = 1 to register 0xC clears the interrupt status on the next peripheral clock edge. The same write restarts the elapsed time and the overflow tracking, so the next interrupt comes one full interval later. Writing bit 0 = 0 has no effect.
- R8: Writing 0 to register 0x8 restarts the elapsed time, which moves the next overflow one full interval later. A nonzero write to register 0x8 is ignored.
- R9: Register 0x8 returns, in bits [11:0], the number of whole 2^PRESC_W-cycle units that have passed in the current interval.
- R10: Clearing the enable bit stops counting and forgets an earlier overflow. After re-enabling, the reset request comes only after two full intervals.
- R11: A write to the control, period or elapsed register takes effect on the third oscillator edge after the bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Peripheral bus clock |
| presetn | input | 1 | Active-low asynchronous reset, bus domain |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid while psel is high |
| osc_clk | input | 1 | Oscillator clock for the counter |
| osc_rst_n | input | 1 | Active-low asynchronous reset, oscillator domain |
| irq_o | output | 1 | First-overflow interrupt, bus domain |
| rst_req_o | output | 1 | Reset request pulse, oscillator domain |

## Verification
Let T be the oscillator cycle on which a control, elapsed or kick write is committed. The restart lands on edge T+3. The first overflow then lands on edge T+3+16(N+1), and the reset request on edge T+3+32(N+1). The interrupt takes up to three more peripheral edges to reach `irq_o`.

The scoreboard queues each expected edge of `irq_o` or `rst_req_o` as a window from T+U+1 to T+U+7. Here U is the interval term: 16(N+1) for an interrupt and 32(N+1) for a reset request. The monitor samples on the falling oscillator edge and matches each rising edge against the head of the queue. Any rising edge it does not expect is a failure.

An interrupt clear must already show on the first read after the write. The bench reads the elapsed count in the middle of a 16-cycle unit, where the synchronised value is stable.

// File: rtl/wd_pkg.sv
package wd_pkg;

    // Bus byte offsets of the four registers
    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_PER  = 4'h4;
    localparam logic [3:0] OFS_ELAP = 4'h8;
    localparam logic [3:0] OFS_IRQ  = 4'hC;

    // Indices of the events that cross from the bus into the oscillator domain
    localparam int XING_EN   = 0;
    localparam int XING_PER  = 1;
    localparam int XING_TIM  = 2;
    localparam int XING_KICK = 3;
    localparam int NUM_XING  = 4;

endpackage

// File: rtl/wd_tgl_sync.sv
// Turns a toggle from another clock domain into a one-cycle pulse.
module wd_tgl_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_i,
    output logic pulse_o
);
    logic [2:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[1:0], tgl_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign pulse_o = sh_q[2] ^ sh_q[1];
endmodule

// File: rtl/wd_gray_sync.sv
// Carries a counter that moves in steps of one from one domain to another as Gray code.
module wd_gray_sync #(
    parameter int W = 12
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic [W-1:0] bin_i,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic [W-1:0] bin_o
);
    logic [W-1:0] gray_d, gray_q;
    logic [W-1:0] s1_q, s2_q;

    always_comb begin
        gray_d = bin_i ^ (bin_i >> 1);
    end

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) gray_q <= '0;
        else            gray_q <= gray_d;
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= gray_q;
            s2_q <= s1_q;
        end
    end

    always_comb begin
        bin_o[W-1] = s2_q[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_o[i] = bin_o[i+1] ^ s2_q[i];
        end
    end
endmodule

// File: rtl/wd_osc_core.sv
// Oscillator-domain counter: prescaler, interval ticks, overflow tracking, reset pulse.
module wd_osc_core #(
    parameter int PRESC_W = 20,
    parameter int PER_W   = 12,
    parameter int RST_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en_i,
    input  logic             en_val_i,
    input  logic             ld_per_i,
    input  logic [PER_W-1:0] per_val_i,
    input  logic             clr_time_i,
    input  logic             kick_i,
    output logic             ovf_tgl_o,
    output logic             rst_req_o,
    output logic [PER_W-1:0] tick_o,
    output logic             run_o,
    output logic             armed_o
);
    localparam int RST_W = $clog2(RST_LEN + 1);

    typedef struct packed {
        logic               en;
        logic [PER_W-1:0]   per;
        logic [PRESC_W-1:0] presc;
        logic [PER_W-1:0]   tick;
        logic               armed;
        logic               ovf_tgl;
        logic [RST_W-1:0]   rst_cnt;
    } core_t;

    core_t d, q;
    logic  ovf;
    logic  restart;
    logic  drop_arm;

    always_comb begin
        d        = q;
        ovf      = 1'b0;
        drop_arm = kick_i | (ld_en_i & ~en_val_i);
        restart  = clr_time_i | drop_arm;

        if (q.rst_cnt != '0) d.rst_cnt = q.rst_cnt - 1'b1;
        if (ld_per_i)        d.per     = per_val_i;
        if (ld_en_i)         d.en      = en_val_i;

        if (restart) begin
            d.presc = '0;
            d.tick  = '0;
            if (drop_arm) d.armed = 1'b0;
        end else if (q.en) begin
            d.presc = q.presc + 1'b1;
            if (&q.presc) begin
                if (q.tick >= q.per) begin
                    d.tick = '0;
                    ovf    = 1'b1;
                end else begin
                    d.tick = q.tick + 1'b1;
                end
            end
        end

        if (ovf) begin
            if (!q.armed) begin
                d.armed   = 1'b1;
                d.ovf_tgl = ~q.ovf_tgl;
            end else if (q.rst_cnt == '0) begin
                d.rst_cnt = RST_W'(RST_LEN);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ovf_tgl_o = q.ovf_tgl;
    assign rst_req_o = (q.rst_cnt != '0);
    assign tick_o    = q.tick;
    assign run_o     = q.en;
    assign armed_o   = q.armed;
endmodule

// File: rtl/wd_regs.sv
// Bus-domain register file: shadow copies, crossing toggles, interrupt status.
module wd_regs
    import wd_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int PER_W  = 12
) (
    input  logic                pclk,
    input  logic                presetn,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [DATA_W-1:0]   pwdata,
    output logic [DATA_W-1:0]   prdata,
    input  logic                ovf_pls_i,
    input  logic [PER_W-1:0]    tick_i,
    output logic                en_o,
    output logic [PER_W-1:0]    per_o,
    output logic [NUM_XING-1:0] xing_tgl_o,
    output logic                irq_o
);
    typedef struct packed {
        logic                en;
        logic [PER_W-1:0]    per;
        logic [NUM_XING-1:0] tgl;
        logic                irq;
    } regs_t;

    regs_t d, q;
    logic  wr;
    logic  hit_ctrl, hit_per, hit_elap, hit_irq;

    always_comb begin
        hit_ctrl = (paddr == ADDR_W'(OFS_CTRL));
        hit_per  = (paddr == ADDR_W'(OFS_PER));
        hit_elap = (paddr == ADDR_W'(OFS_ELAP));
        hit_irq  = (paddr == ADDR_W'(OFS_IRQ));
        wr       = psel & penable & pwrite;
    end

    always_comb begin
        d = q;
        if (wr && hit_ctrl) begin
            d.en           = pwdata[0];
            d.tgl[XING_EN] = ~q.tgl[XING_EN];
        end
        if (wr && hit_per) begin
            d.per           = pwdata[DATA_W-1 -: PER_W];
            d.tgl[XING_PER] = ~q.tgl[XING_PER];
        end
        if (wr && hit_elap && (pwdata == '0)) begin
            d.tgl[XING_TIM] = ~q.tgl[XING_TIM];
        end
        if (wr && hit_irq && pwdata[0]) begin
            d.irq            = 1'b0;
            d.tgl[XING_KICK] = ~q.tgl[XING_KICK];
        end
        // An overflow arriving in the same cycle as a clear keeps the status set
        if (ovf_pls_i) d.irq = 1'b1;
    end

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) q <= '0;
        else          q <= d;
    end

    always_comb begin
        prdata = '0;
        if (psel) begin
            if (hit_ctrl) prdata[0]                  = q.en;
            if (hit_per)  prdata[DATA_W-1 -: PER_W]  = q.per;
            if (hit_elap) prdata[PER_W-1:0]          = tick_i;
            if (hit_irq)  prdata[0]                  = q.irq;
        end
    end

    assign en_o       = q.en;
    assign per_o      = q.per;
    assign xing_tgl_o = q.tgl;
    assign irq_o      = q.irq;
endmodule

// File: rtl/wd_dual_ovf.sv
module wd_dual_ovf
    import wd_pkg::*;
#(
    parameter int PRESC_W = 20,
    parameter int PER_W   = 12,
    parameter int RST_LEN = 16,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              osc_clk,
    input  logic              osc_rst_n,
    output logic              irq_o,
    output logic              rst_req_o
);
    logic                en_sh;
    logic [PER_W-1:0]    per_sh;
    logic [NUM_XING-1:0] xing_tgl;
    logic [NUM_XING-1:0] xing_pls;
    logic                ovf_tgl;
    logic                ovf_pls;
    logic [PER_W-1:0]    tick_osc;
    logic [PER_W-1:0]    tick_bus;
    logic                core_run;
    logic                core_armed;

    wd_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PER_W  (PER_W)
    ) u_regs (
        .pclk       (pclk),
        .presetn    (presetn),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .pwdata     (pwdata),
        .prdata     (prdata),
        .ovf_pls_i  (ovf_pls),
        .tick_i     (tick_bus),
        .en_o       (en_sh),
        .per_o      (per_sh),
        .xing_tgl_o (xing_tgl),
        .irq_o      (irq_o)
    );

    for (genvar g = 0; g < NUM_XING; g++) begin : g_to_osc
        wd_tgl_sync u_sync (
            .clk     (osc_clk),
            .rst_n   (osc_rst_n),
            .tgl_i   (xing_tgl[g]),
            .pulse_o (xing_pls[g])
        );
    end

    wd_tgl_sync u_ovf_sync (
        .clk     (pclk),
        .rst_n   (presetn),
        .tgl_i   (ovf_tgl),
        .pulse_o (ovf_pls)
    );

    wd_gray_sync #(
        .W (PER_W)
    ) u_tick_sync (
        .src_clk   (osc_clk),
        .src_rst_n (osc_rst_n),
        .bin_i     (tick_osc),
        .dst_clk   (pclk),
        .dst_rst_n (presetn),
        .bin_o     (tick_bus)
    );

    wd_osc_core #(
        .PRESC_W (PRESC_W),
        .PER_W   (PER_W),
        .RST_LEN (RST_LEN)
    ) u_core (
        .clk        (osc_clk),
        .rst_n      (osc_rst_n),
        .ld_en_i    (xing_pls[XING_EN]),
        .en_val_i   (en_sh),
        .ld_per_i   (xing_pls[XING_PER]),
        .per_val_i  (per_sh),
        .clr_time_i (xing_pls[XING_TIM]),
        .kick_i     (xing_pls[XING_KICK]),
        .ovf_tgl_o  (ovf_tgl),
        .rst_req_o  (rst_req_o),
        .tick_o     (tick_osc),
        .run_o      (core_run),
        .armed_o    (core_armed)
    );
endmodule

// File: rtl/wd_dual_ovf_chk.sv
module wd_dual_ovf_chk #(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int RST_LEN = 16
) (
    input logic              pclk,
    input logic              presetn,
    input logic              osc_clk,
    input logic              osc_rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic              irq_o,
    input logic              rst_req_o,
    input logic              ovf_pls,
    input logic              core_run,
    input logic              core_armed
);
    int unsigned hi_run;

    always_ff @(posedge osc_clk or negedge osc_rst_n) begin
        if (!osc_rst_n)     hi_run <= 0;
        else if (rst_req_o) hi_run <= hi_run + 1;
        else                hi_run <= 0;
    end

    // R4: the interrupt rises only after an overflow pulse reaches the bus domain
    a_r4_irq_from_ovf: assert property (@(posedge pclk) disable iff (!presetn)
        $rose(irq_o) |-> $past(ovf_pls));

    // R5: a reset request needs an earlier overflow that is still unserviced
    a_r5_second_ovf: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        $rose(rst_req_o) |-> $past(core_armed));

    // R6: the pulse length is fixed
    a_r6_rst_len: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        $fell(rst_req_o) |-> (hi_run == RST_LEN));

    // R7: a clear write drops the interrupt on the next edge unless an overflow arrives with it
    a_r7_kick_clears: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && pwrite && paddr == ADDR_W'(12) && pwdata[0] && !ovf_pls) |=> !irq_o);

    // R10: a stopped counter cannot start a reset request
    a_r10_stopped_quiet: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        !core_run |=> !$rose(rst_req_o));
endmodule

bind wd_dual_ovf wd_dual_ovf_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .RST_LEN (RST_LEN)
) u_chk (
    .pclk       (pclk),
    .presetn    (presetn),
    .osc_clk    (osc_clk),
    .osc_rst_n  (osc_rst_n),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .pwdata     (pwdata),
    .irq_o      (irq_o),
    .rst_req_o  (rst_req_o),
    .ovf_pls    (ovf_pls),
    .core_run   (core_run),
    .core_armed (core_armed)
);

// File: tb/wd_dual_ovf_tb.sv
`timescale 1ns/1ps
module wd_dual_ovf_tb;
    localparam int PW   = 4;
    localparam int UNIT = 1 << PW;
    localparam int K_IRQ = 0;
    localparam int K_RST = 1;

    logic        pclk = 1'b0, osc_clk = 1'b0;
    logic        presetn = 1'b0, osc_rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [3:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq_o, rst_req_o;

    always #2 pclk    = ~pclk;
    always #5 osc_clk = ~osc_clk;

    wd_dual_ovf #(.PRESC_W(PW)) u_dut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .osc_clk(osc_clk), .osc_rst_n(osc_rst_n),
        .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    typedef struct {
        int     kind;
        longint lo;
        longint hi;
        string  req;
    } exp_t;

    exp_t   exp_q[$];
    longint osc_cyc = 0;
    int     n_chk = 0, n_fail = 0;
    string  quiet_req = "R3";
    logic   irq_prev = 1'b0, rst_prev = 1'b0;
    int     rst_w = 0;

    always @(posedge osc_clk) osc_cyc <= osc_cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic push_exp(input int kind, input longint c, input longint span, input string req);
        exp_t e;
        e.kind = kind; e.lo = c + span + 1; e.hi = c + span + 7; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic on_event(input int kind);
        exp_t e;
        if (exp_q.size() == 0 || exp_q[0].kind != kind) begin
            n_chk++; n_fail++;
            $display("FAIL %s unexpected %s edge: actual=cycle %0d expected=none",
                     quiet_req, (kind == K_IRQ) ? "irq" : "rst", osc_cyc);
        end else begin
            e = exp_q.pop_front();
            chk(osc_cyc >= e.lo && osc_cyc <= e.hi, e.req,
                (kind == K_IRQ) ? "irq rise cycle (lower bound shown)" : "rst rise cycle (lower bound shown)",
                osc_cyc, e.lo);
        end
    endtask

    // Monitor: samples on the falling oscillator edge
    always @(negedge osc_clk) begin
        if (osc_rst_n && presetn) begin
            if (irq_o && !irq_prev)    on_event(K_IRQ);
            if (rst_req_o && !rst_prev) on_event(K_RST);
            if (rst_req_o) rst_w = rst_prev ? rst_w + 1 : 1;
            else if (rst_prev) chk(rst_w == 16, "R6", "rst pulse width", rst_w, 16);
        end
        irq_prev = irq_o;
        rst_prev = rst_req_o;
    end

    task automatic apb_wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge pclk); #1; psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(posedge pclk); #1; penable = 1'b1;
        @(posedge pclk); #1; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [3:0] a, output logic [31:0] d);
        @(posedge pclk); #1; psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(posedge pclk); #1; penable = 1'b1; d = prdata;
        @(posedge pclk); #1; psel = 1'b0; penable = 1'b0;
    endtask

    task automatic wait_osc(input longint t);
        while (osc_cyc < t) @(posedge osc_clk);
        #1;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge pclk);
    endtask

    task automatic cleanup();
        apb_wr(4'h0, 32'h0);
        apb_wr(4'hC, 32'h1);
        while (rst_req_o) @(posedge osc_clk);
        wait_osc(osc_cyc + 8);
    endtask

    initial begin
        repeat (150000) @(posedge pclk);
        n_chk++; n_fail++;
        $display("FAIL R11 watchdog expired: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        longint c0, c1;

        repeat (5) @(posedge osc_clk);
        #1; presetn = 1'b1; osc_rst_n = 1'b1;

        // R1: reset state
        apb_rd(4'h0, rd); chk(rd == 0, "R1", "control after reset", rd, 0);
        apb_rd(4'h4, rd); chk(rd == 0, "R1", "period after reset", rd, 0);
        apb_rd(4'h8, rd); chk(rd == 0, "R1", "elapsed after reset", rd, 0);
        apb_rd(4'hC, rd); chk(rd == 0, "R1", "irq status after reset", rd, 0);
        chk(irq_o == 0 && rst_req_o == 0, "R1", "outputs after reset", {irq_o, rst_req_o}, 0);

        // R2: period field
        apb_wr(4'h4, 32'hABCF_FFFF);
        apb_rd(4'h4, rd); chk(rd == 32'hABC0_0000, "R2", "period readback", rd, 32'hABC0_0000);
        apb_wr(4'h4, 32'h001F_FFFF);
        apb_rd(4'h4, rd); chk(rd == 32'h0010_0000, "R2", "period N=1 readback", rd, 32'h0010_0000);

        // R3: disabled -> nothing counts (monitor flags any edge)
        quiet_req = "R3";
        wait_osc(osc_cyc + 120);
        apb_rd(4'h8, rd); chk(rd == 0, "R3", "elapsed while disabled", rd, 0);
        chk(irq_o == 0, "R3", "irq while disabled", irq_o, 0);

        // R4 R5 R11: first overflow interrupt, second overflow reset
        quiet_req = "R5";
        apb_wr(4'h0, 32'h1); c0 = osc_cyc;
        push_exp(K_IRQ, c0, 2 * UNIT, "R4 R11");
        push_exp(K_RST, c0, 4 * UNIT, "R5");
        apb_rd(4'h0, rd); chk(rd == 1, "R3", "control readback", rd, 1);
        while (exp_q.size() == 2) @(posedge pclk);
        wait_osc(osc_cyc + 2);
        chk(rst_req_o == 0, "R5", "no reset after a single overflow", rst_req_o, 0);
        apb_rd(4'hC, rd); chk(rd == 1, "R4", "irq status after first overflow", rd, 1);
        drain();
        cleanup();

        // R7: service write
        quiet_req = "R7";
        apb_wr(4'h0, 32'h1); c0 = osc_cyc;
        push_exp(K_IRQ, c0, 2 * UNIT, "R7");
        drain();
        apb_wr(4'hC, 32'h0);
        apb_rd(4'hC, rd); chk(rd == 1, "R7", "zero write leaves irq set", rd, 1);
        apb_wr(4'hC, 32'h1); c1 = osc_cyc;
        chk(irq_o == 0, "R7", "irq_o right after clear", irq_o, 0);
        apb_rd(4'hC, rd); chk(rd == 0, "R7", "irq status after clear", rd, 0);
        push_exp(K_IRQ, c1, 2 * UNIT, "R7");
        drain();
        cleanup();

        // R10: disabling forgets the overflow
        quiet_req = "R10";
        apb_wr(4'h0, 32'h1); c0 = osc_cyc;
        push_exp(K_IRQ, c0, 2 * UNIT, "R10");
        drain();
        apb_wr(4'h0, 32'h0);
        wait_osc(osc_cyc + 100);
        chk(rst_req_o == 0, "R10", "no reset while disabled", rst_req_o, 0);
        apb_rd(4'h8, rd); chk(rd == 0, "R10", "elapsed cleared by disable", rd, 0);
        apb_wr(4'h0, 32'h1); c1 = osc_cyc;
        push_exp(K_RST, c1, 4 * UNIT, "R10");
        drain();
        cleanup();

        // R8 R9: elapsed count, N=7
        quiet_req = "R8";
        apb_wr(4'h4, 32'h0070_0000);
        apb_wr(4'h0, 32'h1); c0 = osc_cyc;
        wait_osc(c0 + 60);
        apb_rd(4'h8, rd); chk(rd == 3, "R9", "elapsed units at 60 cycles", rd, 3);
        apb_wr(4'h8, 32'h5);
        wait_osc(c0 + 75);
        apb_rd(4'h8, rd); chk(rd == 4, "R8", "nonzero elapsed write ignored", rd, 4);
        apb_wr(4'h8, 32'h0); c1 = osc_cyc;
        push_exp(K_IRQ, c1, 8 * UNIT, "R8");
        wait_osc(c1 + 10);
        apb_rd(4'h8, rd); chk(rd == 0, "R8", "elapsed after zero write", rd, 0);
        drain();
        cleanup();

        chk(exp_q.size() == 0, "R4", "all expected edges seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule